// File: doc/BRIEF.md
# AXI Read Transaction Watchdog with Trace

This block sits beside an AXI read path and only listens. Each accepted read address is held in one of a few tracking slots together with its ID, its address and a duration counter. The slot is released when the final data beat for that ID is consumed. Each completed read is written into a small circular history. A read that stays open for a programmable number of cycles fires a trigger. This typically catches a slave that presents data the master never accepts.

While the trigger has not fired, the trace output stays silent. When it fires, the block freezes the history and streams it out over a valid/ready port, oldest record first. It then sends one final record that names the stuck read and carries a last marker. Every record holds the read's ID and address. The trigger stays high until software pulses the clear input. The clear forgets all open reads, empties the history and re-arms monitoring.

Top module: `axi_rd_watchdog`

## Requirements
- R1: The duration counter starts at the address handshake (ar_valid_i and ar_ready_i high at a clock edge, edge a). A read whose completion handshake (r_valid_i, r_ready_i and r_last_i high) falls on or before edge a+T, where T = cfg_threshold_i, never fires. A read still open at edge a+T raises trigger_o on exactly that edge.
- R2: A read whose data is presented with r_valid_i high while r_ready_i stays low counts as open and fires per R1.
- R3: The threshold is a 15-bit value accepted from 1 to 16384 inclusive.
- R4: tr_valid_o stays low whenever trigger_o is low.
- R5: After the trigger fires, the trace sends the buffered completed reads from oldest to newest, then exactly one record for the read that timed out. tr_last_o is high on that final record only.
- R6: Each trace record carries the read's ID on tr_id_o and its address on tr_addr_o.
- R7: The history keeps the 8 most recently completed reads. When full, a new completion overwrites the oldest entry.
- R8: Up to 4 reads with distinct IDs may be open at once, each timed on its own. The trigger fires once and stays high, and no record follows the final one until a clear.
- R9: A one-cycle pulse on trig_clear_i drops trigger_o and tr_valid_o on the next cycle. It empties the history and discards all open reads.
- R10: While tr_valid_o is high and tr_ready_i is low, the record on the trace port holds unchanged and tr_valid_o stays high. No record is lost.
- R11: With cfg_enable_i low the trigger never fires, and reads completing in that time are not added to the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_enable_i | input | 1 | Enables the trigger and history recording |
| cfg_threshold_i | input | 15 | Duration limit in cycles (1 to 16384) |
| trig_clear_i | input | 1 | Clears trigger, history and open reads |
| ar_valid_i | input | 1 | Observed read address valid |
| ar_ready_i | input | 1 | Observed read address ready |
| ar_id_i | input | 4 | Observed read address ID |
| ar_addr_i | input | 32 | Observed read address |
| r_valid_i | input | 1 | Observed read data valid |
| r_ready_i | input | 1 | Observed read data ready |
| r_id_i | input | 4 | Observed read data ID |
| r_last_i | input | 1 | Observed final data beat |
| trigger_o | output | 1 | Sticky timeout trigger |
| tr_valid_o | output | 1 | Trace record valid |
| tr_ready_i | input | 1 | Trace record accepted by the sink |
| tr_id_o | output | 4 | Trace record ID |
| tr_addr_o | output | 32 | Trace record address |
| tr_last_o | output | 1 | Marks the timed-out read's record |

## Verification
The assertions assume the observed bus never has more than four reads open at once. They also assume no two open reads share an ID, so every completion matches at most one slot. The stimulus keeps to this by issuing reads one after another, except in one directed case with two overlapping reads that use different fixed IDs. Completions for reads dropped by a clear are never sent. The threshold is only changed while no read is open.

// File: rtl/axi_wd_pkg.sv
package axi_wd_pkg;
  typedef enum logic [1:0] {
    DS_IDLE,
    DS_HIST,
    DS_OFF,
    DS_DONE
  } dump_st_e;
endpackage

// File: rtl/axi_wd_slots.sv
module axi_wd_slots #(
  parameter int SLOTS  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15,
  localparam int REC_W = ID_W + ADDR_W,
  localparam int SL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              acc_i,
  input  logic [ID_W-1:0]   acc_id_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              done_i,
  input  logic [ID_W-1:0]   done_id_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              cmp_o,
  output logic [REC_W-1:0]  cmp_rec_o,
  output logic              exp_o,
  output logic [REC_W-1:0]  exp_rec_o
);
  logic              vld_q  [SLOTS];
  logic [ID_W-1:0]   id_q   [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q  [SLOTS];

  logic [SLOTS-1:0] hit, exp_v;
  logic             alloc_ok;
  logic [SL_W-1:0]  alloc_idx, hit_idx, exp_idx;

  // lowest index wins for allocation, match and expiry
  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    hit_idx   = '0;
    exp_idx   = '0;
    hit       = '0;
    exp_v     = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      hit[i]   = done_i && vld_q[i] && (id_q[i] == done_id_i);
      exp_v[i] = vld_q[i] && !hit[i] && (cnt_q[i] >= thresh_i);
      if (!vld_q[i]) begin
        alloc_ok  = 1'b1;
        alloc_idx = SL_W'(i);
      end
      if (hit[i])   hit_idx = SL_W'(i);
      if (exp_v[i]) exp_idx = SL_W'(i);
    end
  end

  assign cmp_o     = |hit;
  assign cmp_rec_o = {id_q[hit_idx], addr_q[hit_idx]};
  assign exp_o     = |exp_v;
  assign exp_rec_o = {id_q[exp_idx], addr_q[exp_idx]};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        id_q[g]   <= '0;
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;
      end else if (hit[g]) begin
        vld_q[g] <= 1'b0;
      end else if (acc_i && alloc_ok && (alloc_idx == SL_W'(g))) begin
        vld_q[g]  <= 1'b1;
        id_q[g]   <= acc_id_i;
        addr_q[g] <= acc_addr_i;
        cnt_q[g]  <= CNT_W'(1);
      end else if (vld_q[g] && (cnt_q[g] < thresh_i)) begin
        cnt_q[g] <= cnt_q[g] + CNT_W'(1);  // saturates at threshold
      end
    end
  end

  assert_one_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  assert_slot_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !flush_i |-> alloc_ok);
endmodule

// File: rtl/axi_wd_hist.sv
module axi_wd_hist #(
  parameter int DEPTH = 8,
  parameter int REC_W = 36,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [REC_W-1:0] wr_rec_i,
  input  logic             start_i,
  input  logic             adv_i,
  output logic             avail_o,
  output logic [REC_W-1:0] rd_rec_o
);
  logic [REC_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_n, rd_ptr_q;
  logic [CW-1:0]    cnt_q, cnt_n, rem_q;

  always_comb begin
    wr_ptr_n = wr_i ? wr_ptr_q + PW'(1) : wr_ptr_q;
    cnt_n    = (wr_i && (cnt_q != CW'(DEPTH))) ? cnt_q + CW'(1) : cnt_q;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wr_rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      rem_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      rem_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      cnt_q    <= cnt_n;
      if (start_i) begin
        // oldest entry sits cnt entries behind the write pointer
        rd_ptr_q <= wr_ptr_n - cnt_n[PW-1:0];
        rem_q    <= cnt_n;
      end else if (adv_i) begin
        rd_ptr_q <= rd_ptr_q + PW'(1);
        rem_q    <= rem_q - CW'(1);
      end
    end
  end

  assign avail_o  = (rem_q != '0);
  assign rd_rec_o = mem_q[rd_ptr_q];

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_adv_has_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rem_q != '0);
endmodule

// File: rtl/axi_rd_watchdog.sv
module axi_rd_watchdog
  import axi_wd_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int SLOTS      = 4,
  parameter int HIST_DEPTH = 8,
  parameter int CNT_W      = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_enable_i,
  input  logic [CNT_W-1:0]  cfg_threshold_i,
  input  logic              trig_clear_i,
  input  logic              ar_valid_i,
  input  logic              ar_ready_i,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic              r_valid_i,
  input  logic              r_ready_i,
  input  logic [ID_W-1:0]   r_id_i,
  input  logic              r_last_i,
  output logic              trigger_o,
  output logic              tr_valid_o,
  input  logic              tr_ready_i,
  output logic [ID_W-1:0]   tr_id_o,
  output logic [ADDR_W-1:0] tr_addr_o,
  output logic              tr_last_o
);
  localparam int REC_W = ID_W + ADDR_W;

  logic             cmp, expd, fire, hist_wr, hist_avail, hist_adv, trig_q;
  logic [REC_W-1:0] cmp_rec, exp_rec, hist_rec, off_rec_q, tr_rec;
  dump_st_e         st_q;

  axi_wd_slots #(
    .SLOTS(SLOTS), .ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (trig_clear_i),
    .acc_i      (ar_valid_i && ar_ready_i),
    .acc_id_i   (ar_id_i),
    .acc_addr_i (ar_addr_i),
    .done_i     (r_valid_i && r_ready_i && r_last_i),
    .done_id_i  (r_id_i),
    .thresh_i   (cfg_threshold_i),
    .cmp_o      (cmp),
    .cmp_rec_o  (cmp_rec),
    .exp_o      (expd),
    .exp_rec_o  (exp_rec)
  );

  assign fire    = cfg_enable_i && expd && !trig_q && !trig_clear_i;
  assign hist_wr = cfg_enable_i && cmp && !trig_q && !trig_clear_i;
  assign hist_adv = (st_q == DS_HIST) && hist_avail && tr_ready_i;

  axi_wd_hist #(.DEPTH(HIST_DEPTH), .REC_W(REC_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (trig_clear_i),
    .wr_i     (hist_wr),
    .wr_rec_i (cmp_rec),
    .start_i  (fire),
    .adv_i    (hist_adv),
    .avail_o  (hist_avail),
    .rd_rec_o (hist_rec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q    <= 1'b0;
      off_rec_q <= '0;
      st_q      <= DS_IDLE;
    end else if (trig_clear_i) begin
      trig_q <= 1'b0;
      st_q   <= DS_IDLE;
    end else begin
      if (fire) begin
        trig_q    <= 1'b1;
        off_rec_q <= exp_rec;
      end
      unique case (st_q)
        DS_IDLE: if (fire) st_q <= DS_HIST;
        DS_HIST: if (!hist_avail) st_q <= DS_OFF;
        DS_OFF:  if (tr_ready_i) st_q <= DS_DONE;
        default: st_q <= DS_DONE;
      endcase
    end
  end

  assign trigger_o  = trig_q;
  assign tr_valid_o = ((st_q == DS_HIST) && hist_avail) || (st_q == DS_OFF);
  assign tr_last_o  = (st_q == DS_OFF);
  assign tr_rec     = (st_q == DS_OFF) ? off_rec_q : hist_rec;
  assign tr_id_o    = tr_rec[REC_W-1:ADDR_W];
  assign tr_addr_o  = tr_rec[ADDR_W-1:0];

  assert_silent_untriggered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_valid_o |-> trigger_o);
  assert_hold_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_valid_o && !tr_ready_i && !trig_clear_i |=>
      tr_valid_o && $stable(tr_id_o) && $stable(tr_addr_o) && $stable(tr_last_o));
  assert_trigger_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_o && !trig_clear_i |=> trigger_o);
  assert_clear_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_clear_i |=> !trigger_o && !tr_valid_o);
  assert_no_fire_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_enable_i && !trigger_o |=> !trigger_o);
endmodule

// File: tb/sim_axi_rd_watchdog.sv
`timescale 1ns/1ps
module sim_axi_rd_watchdog;
  logic        clk = 1'b0;
  logic        rst_n, cfg_en, clr;
  logic [14:0] cfg_thr;
  logic        arv, arr, rv, rr, rl;
  logic [3:0]  arid, rid;
  logic [31:0] araddr;
  logic        trig, tv, tready, tlast;
  logic [3:0]  tid;
  logic [31:0] taddr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done_flag = 0;
  bit  model_en = 1;
  logic [3:0]  hq_id[$];
  logic [31:0] hq_addr[$];
  logic [3:0]  off_id;
  logic [31:0] off_addr;

  always #10 clk = ~clk;

  axi_rd_watchdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(cfg_en), .cfg_threshold_i(cfg_thr),
    .trig_clear_i(clr), .ar_valid_i(arv), .ar_ready_i(arr), .ar_id_i(arid),
    .ar_addr_i(araddr), .r_valid_i(rv), .r_ready_i(rr), .r_id_i(rid), .r_last_i(rl),
    .trigger_o(trig), .tr_valid_o(tv), .tr_ready_i(tready), .tr_id_o(tid),
    .tr_addr_o(taddr), .tr_last_o(tlast)
  );

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void hist_push(input logic [3:0] id, input logic [31:0] addr);
    if (!model_en) return;
    hq_id.push_back(id);
    hq_addr.push_back(addr);
    if (hq_id.size() > 8) begin
      void'(hq_id.pop_front());
      void'(hq_addr.pop_front());
    end
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue_ar(input logic [3:0] id, input logic [31:0] addr);
    arv = 1; arr = 1; arid = id; araddr = addr;
    step();
    arv = 0; arr = 0;
  endtask

  task automatic complete(input logic [3:0] id, input logic [31:0] addr);
    rv = 1; rr = 1; rl = 1; rid = id;
    step();
    rv = 0; rr = 0;
    hist_push(id, addr);
  endtask

  task automatic read_ok(input logic [3:0] id, input logic [31:0] addr, input int d);
    issue_ar(id, addr);
    repeat (d - 1) step();
    complete(id, addr);
    chk_eq("R1 read done within threshold leaves trigger low", trig, 0);
  endtask

  task automatic hang(input logic [3:0] id, input logic [31:0] addr, input int thr,
                      input bit expect_fire);
    bit early = 0;
    issue_ar(id, addr);
    rv = 1; rr = 0; rl = 1; rid = id;
    for (int k = 1; k < thr; k++) begin
      step();
      if (trig || tv) early = 1;
    end
    chk_eq("R1/R4 no trigger or trace before threshold", early, 0);
    step();
    if (expect_fire) chk_eq("R1/R2 trigger on threshold edge", trig, 1);
    else             chk_eq("R11 disabled monitor does not fire", trig, 0);
    off_id = id; off_addr = addr;
  endtask

  task automatic collect();
    logic [3:0]  eid[$];
    logic [31:0] eaddr[$];
    int got = 0;
    int n;
    bit stall = 0;
    bit fin = 0;
    bit extra = 0;
    logic [36:0] held = '0;
    eid = hq_id; eaddr = hq_addr;
    eid.push_back(off_id); eaddr.push_back(off_addr);
    n = eid.size();
    for (int c = 0; c < 600 && !fin; c++) begin
      if (stall) chk_eq("R10 record held under backpressure", {tv, tid, taddr, tlast}, {1'b1, held});
      tready = ($urandom % 10) < 6;
      stall = tv && !tready;
      held = {tid, taddr, tlast};
      if (tv && tready) begin
        if (got < n) begin
          chk_eq("R5/R6 trace id in order", tid, eid[got]);
          chk_eq("R6 trace address", taddr, eaddr[got]);
          chk_eq("R5 last marker only on offender", tlast, got == n - 1);
        end
        got++;
        if (tlast) fin = 1;
      end
      step();
    end
    tready = 1;
    chk_eq("R5/R7 trace record count", got, n);
    for (int c = 0; c < 10; c++) begin
      if (tv) extra = 1;
      step();
    end
    tready = 0;
    chk_eq("R8 no record after final one", extra, 0);
    chk_eq("R8 trigger stays high", trig, 1);
  endtask

  task automatic do_clear();
    rv = 0; rr = 0;
    clr = 1;
    step();
    clr = 0;
    chk_eq("R9 clear drops trigger", trig, 0);
    chk_eq("R9 clear drops trace valid", tv, 0);
    hq_id.delete(); hq_addr.delete();
  endtask

  initial begin
    #4000000;
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_en = 1; cfg_thr = 15'd20; clr = 0;
    arv = 0; arr = 0; arid = 0; araddr = 0;
    rv = 0; rr = 0; rid = 0; rl = 0; tready = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk_eq("R4 reset trigger low", trig, 0);
    chk_eq("R4 reset trace idle", tv, 0);

    // phase 1: T=20, boundary latencies plus random ones
    read_ok(4'h1, 32'h1000_0000, 1);
    read_ok(4'h2, 32'h2000_0040, 20);
    for (int i = 0; i < 3; i++)
      read_ok(4'($urandom), $urandom, 1 + int'($urandom % 20));
    hang(4'h5, 32'hDEAD_0100, 20, 1);
    collect();
    do_clear();

    // phase 2: T=30, history overflow and two overlapping reads
    cfg_thr = 15'd30;
    for (int i = 0; i < 12; i++)
      read_ok(4'($urandom), $urandom, 1 + int'($urandom % 30));
    begin
      bit early = 0;
      issue_ar(4'h3, 32'hA000_0003);   // edge a
      issue_ar(4'h9, 32'hB000_0009);   // edge a+1
      step(); step();
      complete(4'h9, 32'hB000_0009);   // edge a+4
      rv = 1; rr = 0; rl = 1; rid = 4'h3;
      for (int k = 5; k < 30; k++) begin
        step();
        if (trig || tv) early = 1;
      end
      chk_eq("R8 overlapped read no early trigger", early, 0);
      step();
      chk_eq("R8 stuck read of two fires on its own threshold", trig, 1);
      off_id = 4'h3; off_addr = 32'hA000_0003;
    end
    collect();
    do_clear();

    // phase 3: disabled monitoring
    cfg_en = 0; cfg_thr = 15'd5; model_en = 0;
    read_ok(4'h6, 32'h0600_0000, 2);
    hang(4'h7, 32'h0700_0000, 20, 0);
    chk_eq("R11 no trace while disabled", tv, 0);
    do_clear();
    cfg_en = 1; model_en = 1;
    read_ok(4'hC, 32'h0C00_00C0, 3);
    hang(4'hD, 32'h0D00_00D0, 5, 1);
    collect();
    do_clear();

    // phase 4: largest threshold, empty history
    cfg_thr = 15'd16384;
    hang(4'hE, 32'hEEEE_0000, 16384, 1);
    chk_eq("R3 maximum threshold fires", trig, 1);
    collect();
    do_clear();

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule